// File: doc/BRIEF.md
# Audio Serial Clock Generator

The block produces the bit clock and the frame clock for a stereo audio serial port. One 16-bit control register, written through a plain address/data/strobe port, chooses between master and slave operation. It also sets the polarity of both clocks, a coded bit-clock divide ratio, a log2-coded frame length and a framing style. In master mode the block drives both clocks and raises their output enables. In slave mode it releases the pads and passes the externally supplied clocks through the same polarity logic, so the serial core always sees clocks of one known orientation.

The generator runs from `clk_i`. Each bit-clock half-period lasts a whole number of `clk_i` cycles, equal to the selected ratio. The frame clock changes level only together with a bit-clock falling edge. Divider and framing changes are held back and take effect only at the next frame boundary, so a reprogramming never produces a short pulse on either clock. Polarity and master/slave changes apply at once.

Top module: `audio_clkgen`

## Requirements
- R1: A write with `we_i` high and `addr_i` equal to 0x40 loads the control register on that clock edge. A write to any other address changes nothing on the outputs.
- R2: Control bit 15 set selects master mode: `bclk_oe_o` and `lrck_oe_o` are 1 and the outputs come from the internal generator. Bit 15 clear selects slave mode: both enables are 0, and `bclk_o`/`lrck_o` follow `bclk_i`/`lrck_i` combinationally through the polarity logic.
- R3: Control bit 14 set inverts `bclk_o`, in both modes, starting from the cycle after the write.
- R4: Control bit 13 has reversed sense. With the bit clear, `lrck_o` is the complement of the internal (or external) frame clock. With the bit set, it is passed unchanged.
- R5: The bit-clock code in bits 12:9 sets the half-period in `clk_i` cycles. Codes 0..13 map to 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192. Codes 14 and 15 behave as 1. The bit-clock period is twice the half-period, and the internal bit clock starts low after reset.
- R6: The frame code in bits 8:6 sets the frame length to 16 shifted left by the code, giving 16 to 256 bit-clock periods. Codes 5..7 behave as 256.
- R7: The internal frame clock changes level only at an internal bit-clock falling edge. With framing codes 0..2, it is low for the first half of each frame and high for the second half.
- R8: Framing code 3 in bits 3:2 selects pulse framing. The internal frame clock is high for exactly one bit-clock period, starting at each frame boundary.
- R9: New values of bits 12:2 take effect only at the next frame boundary, which is the bit-clock falling edge that ends the last period of a frame. Until then, the old ratio and frame length stay in force.
- R10: After reset the register is all zero. The block is therefore in slave mode with no bit-clock inversion and `lrck_o` equal to the complement of `lrck_i`. The internal generator starts at the beginning of a frame with ratio 1 and a 16-period frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register write byte address |
| wdata_i | input | 16 | Register write data |
| we_i | input | 1 | Write strobe |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock after source selection and polarity |
| bclk_oe_o | output | 1 | Bit-clock pad drive enable |
| lrck_o | output | 1 | Frame clock after source selection and polarity |
| lrck_oe_o | output | 1 | Frame-clock pad drive enable |

## Verification
Several properties are checked on every cycle. Writes to foreign addresses leave the register untouched. The half-period and bit counters never pass their active limits. The frame clock moves only one cycle after an internal bit-clock falling edge. The active divider settings change only at a frame wrap. Pulse framing drops its pulse after one bit-clock period. Other behaviour is shown only by the bench scenarios: the actual ratio and frame length that each code produces, the reserved codes, the reversed frame polarity, the slave pass-through, and a divider write that leaves the old period running until the boundary.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned FCODE_MAX = 4;
  localparam int unsigned BIT_MST   = 15;
  localparam int unsigned BIT_BINV  = 14;
  localparam int unsigned BIT_LPOL  = 13;
  localparam int unsigned BDIV_LSB  = 9;
  localparam int unsigned FCODE_LSB = 6;
  localparam int unsigned FMT_LSB   = 2;
  localparam logic [1:0]  FMT_PULSE = 2'd3;

  typedef struct packed {
    logic master;
    logic bclk_inv;
    logic lrck_pol;
  } acg_pol_t;

  typedef struct packed {
    logic [3:0] bdiv;
    logic [2:0] fcode;
    logic [1:0] fmt;
  } acg_div_t;

  // half-period length minus one
  function automatic logic [CNT_W-1:0] half_last(input logic [3:0] code);
    int unsigned c;
    int unsigned r;
    c = 32'(code);
    if (c == 0 || c > 13) r = 1;
    else if (c == 1)      r = 2;
    else if (code[0] == 1'b0) r = 32'd1 << (c / 2 + 1);
    else                  r = 32'd3 << ((c - 1) / 2);
    return CNT_W'(r - 1);
  endfunction

  // frame length in bit periods minus one
  function automatic logic [CNT_W-1:0] frame_last(input logic [2:0] code);
    int unsigned c;
    c = 32'(code);
    if (c > FCODE_MAX) c = FCODE_MAX;
    return CNT_W'((32'd16 << c) - 1);
  endfunction
endpackage

// File: rtl/acg_regs.sv
module acg_regs import acg_pkg::*; #(
  parameter int unsigned     ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output acg_pol_t          pol_o,
  output acg_div_t          pend_o
);
  acg_pol_t pol_q;
  acg_div_t pend_q;
  logic     hit;
  logic     unused_bits;

  assign hit         = we_i && (addr_i == CTRL_ADDR);
  assign unused_bits = ^{wdata_i[5:4], wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      pend_q <= '0;
    end else if (hit) begin
      pol_q  <= '{master:   wdata_i[BIT_MST],
                  bclk_inv: wdata_i[BIT_BINV],
                  lrck_pol: wdata_i[BIT_LPOL]};
      pend_q <= '{bdiv:  wdata_i[BDIV_LSB +: 4],
                  fcode: wdata_i[FCODE_LSB +: 3],
                  fmt:   wdata_i[FMT_LSB +: 2]};
    end
  end

  assign pol_o  = pol_q;
  assign pend_o = pend_q;

  a_r1_foreign_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || addr_i != CTRL_ADDR) |=> ($stable(pol_q) && $stable(pend_q)));
endmodule

// File: rtl/acg_bclk_div.sv
module acg_bclk_div #(
  parameter int unsigned CNT_W = acg_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] last_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;
  logic             at_end;

  assign at_end = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = at_end & bclk_q;

  a_r5_half_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
  a_r5_toggle_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bclk_q) |-> $past(cnt_q == last_i));
endmodule

// File: rtl/acg_frame.sv
module acg_frame #(
  parameter int unsigned CNT_W = acg_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic             pulse_i,
  input  logic             pulse_next_i,
  output logic             lrck_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic             lrck_q;

  assign half   = (last_i >> 1) + CNT_W'(1);
  assign wrap_o = fall_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lrck_q <= 1'b0;
    end else if (fall_i) begin
      if (cnt_q == last_i) begin
        cnt_q  <= '0;
        lrck_q <= pulse_next_i;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        lrck_q <= pulse_i ? 1'b0 : ((cnt_q + CNT_W'(1)) >= half);
      end
    end
  end

  assign lrck_o = lrck_q;

  a_r6_bit_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
  a_r7_lrck_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_q) |-> $past(fall_i));
  a_r8_pulse_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && lrck_q && fall_i && !wrap_o) |=> !lrck_q);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen import acg_pkg::*; #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  output logic              bclk_o,
  output logic              bclk_oe_o,
  output logic              lrck_o,
  output logic              lrck_oe_o
);
  acg_pol_t         pol;
  acg_div_t         pend;
  acg_div_t         act_q;
  logic [CNT_W-1:0] hlast;
  logic [CNT_W-1:0] flast;
  logic             bclk_int, fall, lrck_int, wrap;

  acg_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .pol_o(pol), .pend_o(pend)
  );

  // divider settings switch only at a frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= '0;
    else if (wrap) act_q <= pend;
  end

  assign hlast = half_last(act_q.bdiv);
  assign flast = frame_last(act_q.fcode);

  acg_bclk_div #(.CNT_W(CNT_W)) u_bdiv (
    .clk_i, .rst_ni, .last_i(hlast), .bclk_o(bclk_int), .fall_o(fall)
  );

  acg_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .fall_i(fall), .last_i(flast),
    .pulse_i(act_q.fmt == FMT_PULSE), .pulse_next_i(pend.fmt == FMT_PULSE),
    .lrck_o(lrck_int), .wrap_o(wrap)
  );

  assign bclk_o    = (pol.master ? bclk_int : bclk_i) ^ pol.bclk_inv;
  assign lrck_o    = (pol.master ? lrck_int : lrck_i) ^ ~pol.lrck_pol;
  assign bclk_oe_o = pol.master;
  assign lrck_oe_o = pol.master;

  a_r9_cfg_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(wrap));
  a_r9_wrap_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> fall);
endmodule

// File: tb/audio_clkgen_test.sv
`timescale 1ns/100ps
module audio_clkgen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic        we = 0;
  logic        bclk_in = 0, lrck_in = 0;
  logic        bclk_o, bclk_oe_o, lrck_o, lrck_oe_o;

  int checks = 0, fails = 0;
  bit run = 0;

  always #2.5 clk = ~clk;

  audio_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .bclk_i(bclk_in), .lrck_i(lrck_in),
    .bclk_o(bclk_o), .bclk_oe_o(bclk_oe_o), .lrck_o(lrck_o), .lrck_oe_o(lrck_oe_o)
  );

  function automatic int ratio(int c);
    case (c)
      0: return 1;    1: return 2;    2: return 4;    3: return 6;
      4: return 8;    5: return 12;   6: return 16;   7: return 24;
      8: return 32;   9: return 48;   10: return 64;  11: return 96;
      12: return 128; 13: return 192;
      default: return 1;
    endcase
  endfunction

  function automatic int flen(int c);
    return (c > 4) ? 256 : (16 << c);
  endfunction

  function automatic logic [15:0] cfg(bit m, bit bi, bit lp, int bd, int fc, int fm);
    return {m, bi, lp, 4'(bd), 3'(fc), 2'b01, 2'(fm), 2'b00};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_h, m_bclk, m_b, m_lr, m_mst, m_binv, m_lpol;
  int p_bd, p_fc, p_fm, a_bd, a_fc, a_fm;
  int hl, fl;
  bit fall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_bclk = 0; m_b = 0; m_lr = 0; m_mst = 0; m_binv = 0; m_lpol = 0;
      p_bd = 0; p_fc = 0; p_fm = 0; a_bd = 0; a_fc = 0; a_fm = 0;
    end else begin
      hl = ratio(a_bd);
      fl = flen(a_fc);
      fall = (m_bclk == 1) && (m_h == hl - 1);
      if (m_h == hl - 1) begin m_h = 0; m_bclk = 1 - m_bclk; end
      else m_h++;
      if (fall) begin
        if (m_b == fl - 1) begin
          m_b = 0; a_bd = p_bd; a_fc = p_fc; a_fm = p_fm;
          m_lr = (a_fm == 3) ? 1 : 0;
        end else begin
          m_b++;
          m_lr = (a_fm == 3) ? 0 : ((m_b >= fl / 2) ? 1 : 0);
        end
      end
      if (we && addr == 8'h40) begin
        m_mst = wdata[15]; m_binv = wdata[14]; m_lpol = wdata[13];
        p_bd = int'(wdata[12:9]); p_fc = int'(wdata[8:6]); p_fm = int'(wdata[3:2]);
      end
    end
  end

  // per-cycle comparison just after each rising edge
  int eb, el;
  always begin
    @(posedge clk);
    #1;
    if (run) begin
      eb = ((m_mst != 0) ? m_bclk : int'(bclk_in)) ^ m_binv;
      el = ((m_mst != 0) ? m_lr : int'(lrck_in)) ^ (1 - m_lpol);
      chk("R5 R3 bclk_o vs model", int'(bclk_o), eb);
      chk("R7 R4 lrck_o vs model", int'(lrck_o), el);
      chk("R2 bclk_oe_o vs model", int'(bclk_oe_o), m_mst);
      chk("R2 lrck_oe_o vs model", int'(lrck_oe_o), m_mst);
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = 0;
  endtask

  task automatic wait_active();
    int n = 0;
    while (!(a_bd == p_bd && a_fc == p_fc && a_fm == p_fm) && n < 40000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic meas_period(output int p);
    int prev, n, g;
    prev = int'(bclk_o); g = 0;
    while (g < 20000) begin
      @(negedge clk); g++;
      if (prev == 0 && bclk_o == 1) break;
      prev = int'(bclk_o);
    end
    n = 0; prev = 1;
    while (g < 20000) begin
      @(negedge clk); g++; n++;
      if (prev == 0 && bclk_o == 1) break;
      prev = int'(bclk_o);
    end
    p = n;
  endtask

  task automatic meas_frame(output int f);
    int pl, pb, n, g;
    pl = int'(lrck_o); g = 0;
    while (g < 60000) begin
      @(negedge clk); g++;
      if (pl == 0 && lrck_o == 1) break;
      pl = int'(lrck_o);
    end
    pl = 1; pb = int'(bclk_o); n = 0;
    while (g < 60000) begin
      @(negedge clk); g++;
      if (pb == 1 && bclk_o == 0) n++;
      if (pl == 0 && lrck_o == 1) break;
      pl = int'(lrck_o); pb = int'(bclk_o);
    end
    f = n;
  endtask

  task automatic meas_high(output int w);
    int pl, n, g;
    pl = int'(lrck_o); g = 0;
    while (g < 20000) begin
      @(negedge clk); g++;
      if (pl == 0 && lrck_o == 1) break;
      pl = int'(lrck_o);
    end
    n = 1;
    while (g < 20000) begin
      @(negedge clk); g++;
      if (lrck_o == 0) break;
      n++;
    end
    w = n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int v;
  initial begin
    #12;
    chk("R10 reset bclk_o", int'(bclk_o), 0);
    chk("R10 reset lrck_o", int'(lrck_o), 1);
    chk("R10 reset oe", int'(bclk_oe_o), 0);
    @(negedge clk); rst_n = 1; run = 1;

    // slave pass-through and polarity
    @(negedge clk); bclk_in = 1; lrck_in = 0; #1;
    chk("R2 slave bclk pass", int'(bclk_o), 1);
    chk("R4 slave lrck inverted when bit clear", int'(lrck_o), 1);
    wr(8'h40, cfg(0, 1, 1, 0, 0, 0));
    @(negedge clk); bclk_in = 1; lrck_in = 1; #1;
    chk("R3 slave bclk inverted", int'(bclk_o), 0);
    chk("R4 slave lrck direct when bit set", int'(lrck_o), 1);
    chk("R2 slave oe low", int'(bclk_oe_o), 0);

    // foreign address ignored
    wr(8'h44, cfg(1, 0, 1, 0, 0, 0));
    @(negedge clk); #1;
    chk("R1 foreign write oe", int'(bclk_oe_o), 0);
    chk("R1 foreign write bclk inv kept", int'(bclk_o), 0);

    // master, ratio 1, frame 16
    wr(8'h40, cfg(1, 0, 1, 0, 0, 0));
    @(negedge clk);
    chk("R2 master oe", int'(lrck_oe_o), 1);
    wait_active();
    meas_period(v); chk("R5 period code0", v, 2);
    meas_frame(v);  chk("R6 R7 frame code0", v, 16);

    wr(8'h40, cfg(1, 0, 1, 3, 1, 1));
    wait_active();
    meas_period(v); chk("R5 period code3", v, 12);
    meas_frame(v);  chk("R6 frame code1", v, 32);

    wr(8'h40, cfg(1, 0, 1, 13, 0, 2));
    wait_active();
    meas_period(v); chk("R5 period code13", v, 384);
    meas_frame(v);  chk("R6 frame code0 slow", v, 16);

    wr(8'h40, cfg(1, 0, 1, 15, 7, 0));
    wait_active();
    meas_period(v); chk("R5 reserved code15", v, 2);
    meas_frame(v);  chk("R6 reserved code7", v, 256);

    // pulse framing
    wr(8'h40, cfg(1, 0, 1, 2, 0, 3));
    wait_active();
    meas_high(v);   chk("R8 pulse width", v, 8);
    meas_frame(v);  chk("R8 pulse frame", v, 16);

    // deferred divider change
    wr(8'h40, cfg(1, 0, 1, 1, 0, 0));
    wait_active();
    meas_frame(v);
    wr(8'h40, cfg(1, 0, 1, 4, 0, 0));
    meas_period(v); chk("R9 old ratio kept before boundary", v, 4);
    wait_active();
    meas_period(v); chk("R9 new ratio after boundary", v, 16);

    // master inversion applies at once
    wr(8'h40, cfg(1, 1, 0, 4, 0, 0));
    repeat (40) @(negedge clk);
    chk("R3 master inversion oe kept", int'(bclk_oe_o), 1);

    run = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule